// File: doc/BRIEF.md
# DMA Channel Destination Stepper and Acknowledge Driver

This block is the control slice of one channel in a small multi-channel DMA controller. It holds a four-bit channel control word and a destination address register. After every completed transfer beat it moves the destination address according to the selected destination mode and transfer size. It checks every beat against the combinations that are not allowed, and it keeps a sticky error flag when it finds one.

The slice also drives the channel's transfer-acknowledge pin. A programmable cycle select chooses whether the pin is asserted in the read phase or the write phase of a dual-address transfer, and a programmable polarity sets its active level. Both options exist only on the instance built as channel 0. On the other channels those two control bits are forced to zero. The block has no streaming data path, so every pin is a plain level or a single-cycle pulse with no back-pressure. `beat_done` is a one-cycle strobe that the outer sequencer raises once for each finished beat.

Control word layout: bits [1:0] hold the destination mode, bit 2 is the acknowledge-cycle select, and bit 3 is the acknowledge polarity. A register write with `reg_sel`=0 loads the control word from `reg_wdata[3:0]`. A write with `reg_sel`=1 loads the destination address from `reg_wdata`.

Top module: `dma_chan_slice`

## Requirements
- R1: After reset the control word reads 0, the destination address is 0, `cfg_err` is 0 and `dack` is 1 (deasserted low-active level).
- R2: Destination mode 00 holds the address: a legal beat leaves `dst_addr` unchanged.
- R3: Destination mode 01 adds the step on each legal beat. The step is 1, 2, 4 or 16 for `xfer_size` codes 00, 01, 10 and 11 (byte, half-word, word, 16-byte block). The addition wraps modulo 2^ADDR_W.
- R4: Destination mode 10 subtracts the step (1, 2 or 4 for size codes 00, 01, 10) on each legal beat, wrapping modulo 2^ADDR_W.
- R5: A beat is illegal in three cases: mode 11; mode 10 with size code 11; mode 00 with size code 11 while `dst_xy`=1. An illegal beat leaves the address unchanged and sets `cfg_err`, which stays set through later beats.
- R6: A control-word write clears `cfg_err` in the next cycle. If an illegal beat arrives in the same cycle as the write, the flag is set instead.
- R7: The address changes only in the cycle after a `beat_done` pulse or an address write, and it changes once per pulse. An address write in the same cycle as a beat wins over the beat.
- R8: With `dual_addr`=1 and `chan_active`=1, the acknowledge is asserted on `rd_phase` when control bit 2 is 0, and on `wr_phase` when bit 2 is 1.
- R9: With `dual_addr`=0 and `chan_active`=1, the acknowledge is asserted whenever `rd_phase` or `wr_phase` is high, whatever the value of bit 2.
- R10: Control bit 3 sets the polarity: 0 drives `dack` low when asserted, and 1 drives it high when asserted. `dack` is registered and follows its inputs one cycle later.
- R11: While `chan_active`=0, `dack` shows the deasserted level for the current polarity.
- R12: On a channel other than 0, control bits 2 and 3 read back as 0 and writes to them have no effect, so `dack` behaves as low-active with read-phase selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the destination address |
| reg_wdata | input | ADDR_W | Write data |
| xfer_size | input | 2 | Transfer size code: 00 byte, 01 half-word, 10 word, 11 16-byte block |
| dual_addr | input | 1 | 1 for dual-address transfers, 0 for single-address transfers |
| dst_xy | input | 1 | Destination lies in X/Y memory |
| chan_active | input | 1 | Channel currently owns the bus |
| rd_phase | input | 1 | Data read phase strobe |
| wr_phase | input | 1 | Data write phase strobe |
| beat_done | input | 1 | One-cycle pulse at the end of each beat |
| dst_addr | output | ADDR_W | Current destination address |
| ctrl_rd | output | 4 | Control word read-back |
| dack | output | 1 | Transfer acknowledge pin |
| cfg_err | output | 1 | Sticky illegal-setting flag |

## Verification
A corrupted address register or a wrong step shows on `dst_addr` one cycle after the beat that used it. Because the stepper accumulates, the error never heals on later beats. A missed illegal-combination decode shows in the same cycle-after-beat as an address that moved when it should have held, together with a `cfg_err` that stayed low. Errors in acknowledge selection or polarity appear on `dack` one cycle after the phase strobes. The sweep therefore compares `dst_addr`, `cfg_err` and `dack` after every single stimulus rather than only at the end of a sequence.

// File: rtl/dmac_slice_pkg.sv
package dmac_slice_pkg;

  typedef enum logic [1:0] {
    DM_HOLD = 2'b00,
    DM_UP   = 2'b01,
    DM_DOWN = 2'b10,
    DM_RSVD = 2'b11
  } dmode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BLK  = 2'b11
  } xsize_e;

  typedef struct packed {
    logic   ack_lvl;   // bit 3: 1 = high-active acknowledge
    logic   ack_wr;    // bit 2: 1 = acknowledge in write phase (dual mode)
    dmode_e dmode;     // bits 1:0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int STEP_W = 5;

  function automatic logic [STEP_W-1:0] step_mag(input xsize_e sz);
    logic [STEP_W-1:0] m;
    case (sz)
      SZ_BYTE: m = 5'd1;
      SZ_HALF: m = 5'd2;
      SZ_WORD: m = 5'd4;
      default: m = 5'd16;
    endcase
    return m;
  endfunction

  function automatic logic combo_bad(input dmode_e dm, input xsize_e sz, input logic xy);
    logic bad;
    case (dm)
      DM_RSVD: bad = 1'b1;
      DM_DOWN: bad = (sz == SZ_BLK);
      DM_HOLD: bad = (sz == SZ_BLK) && xy;
      default: bad = 1'b0;
    endcase
    return bad;
  endfunction

endpackage

// File: rtl/slice_ctrl_reg.sv
module slice_ctrl_reg
  import dmac_slice_pkg::*;
#(
  parameter int CH_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q
);

  // Acknowledge options survive only on channel 0.
  localparam logic [CTRL_W-1:0] WMASK = (CH_ID == 0) ? {CTRL_W{1'b1}} : 4'b0011;

  ctrl_t ctrl_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_r <= '0;
    else if (wr_ctrl) ctrl_r <= ctrl_t'(wdata & WMASK);
  end

  assign ctrl_q = ctrl_r;

  generate
    if (CH_ID != 0) begin : g_raz_chk
      AST_RAZ_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q.ack_wr == 1'b0) && (ctrl_q.ack_lvl == 1'b0)); // R12
    end
  endgenerate

endmodule

// File: rtl/slice_dst_step.sv
module slice_dst_step
  import dmac_slice_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  dmode_e            dmode,
  input  xsize_e            xsize,
  input  logic              xy,
  output logic [ADDR_W-1:0] nxt,
  output logic              bad
);

  localparam int PAD_W = ADDR_W - STEP_W;

  logic [ADDR_W-1:0] step_ext;

  always_comb begin
    step_ext = {{PAD_W{1'b0}}, step_mag(xsize)};
    bad      = combo_bad(dmode, xsize, xy);
    case (dmode)
      DM_UP:   nxt = cur + step_ext;
      DM_DOWN: nxt = cur - step_ext;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/slice_dst_track.sv
module slice_dst_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              ctrl_wr,
  input  logic              beat,
  input  logic              bad,
  input  logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] addr,
  output logic              err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (beat && !bad) begin
      addr <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            err <= 1'b0;
    else if (beat && bad)  err <= 1'b1;
    else if (ctrl_wr)      err <= 1'b0;
  end

  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && bad && !load) |=> (addr == $past(addr)) && err); // R5
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !(beat && bad)) |=> !err); // R6
  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && !load) |=> $stable(addr)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ctrl_wr) |=> err); // R5

endmodule

// File: rtl/slice_dack_gen.sv
module slice_dack_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic dual,
  input  logic ack_wr,
  input  logic ack_lvl,
  input  logic rd_ph,
  input  logic wr_ph,
  output logic dack_o
);

  logic hit;

  always_comb begin
    if (!active)   hit = 1'b0;
    else if (dual) hit = ack_wr ? wr_ph : rd_ph;
    else           hit = rd_ph | wr_ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dack_o <= 1'b1;
    else        dack_o <= ack_lvl ? hit : ~hit;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (dack_o == ~$past(ack_lvl))); // R11
  AST_SINGLE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !dual && (rd_ph || wr_ph)) |=> (dack_o == $past(ack_lvl))); // R9

endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
  import dmac_slice_pkg::*;
#(
  parameter int CH_ID  = 0,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [1:0]        xfer_size,
  input  logic              dual_addr,
  input  logic              dst_xy,
  input  logic              chan_active,
  input  logic              rd_phase,
  input  logic              wr_phase,
  input  logic              beat_done,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [3:0]        ctrl_rd,
  output logic              dack,
  output logic              cfg_err
);

  ctrl_t             ctrl_q;
  logic              ctrl_wr, addr_wr;
  logic [ADDR_W-1:0] nxt_addr;
  logic              bad_combo;
  xsize_e            sz;

  assign ctrl_wr = reg_wr && !reg_sel;
  assign addr_wr = reg_wr &&  reg_sel;
  assign sz      = xsize_e'(xfer_size);

  slice_ctrl_reg #(.CH_ID(CH_ID)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (ctrl_wr),
    .wdata   (reg_wdata[CTRL_W-1:0]),
    .ctrl_q  (ctrl_q)
  );

  slice_dst_step #(.ADDR_W(ADDR_W)) u_step (
    .cur   (dst_addr),
    .dmode (ctrl_q.dmode),
    .xsize (sz),
    .xy    (dst_xy),
    .nxt   (nxt_addr),
    .bad   (bad_combo)
  );

  slice_dst_track #(.ADDR_W(ADDR_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (addr_wr),
    .load_val (reg_wdata),
    .ctrl_wr  (ctrl_wr),
    .beat     (beat_done),
    .bad      (bad_combo),
    .nxt      (nxt_addr),
    .addr     (dst_addr),
    .err      (cfg_err)
  );

  slice_dack_gen u_dack (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (chan_active),
    .dual    (dual_addr),
    .ack_wr  (ctrl_q.ack_wr),
    .ack_lvl (ctrl_q.ack_lvl),
    .rd_ph   (rd_phase),
    .wr_ph   (wr_phase),
    .dack_o  (dack)
  );

  assign ctrl_rd = ctrl_q;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !addr_wr && !bad_combo && ctrl_q.dmode == DM_UP)
      |=> ((dst_addr - $past(dst_addr)) inside {1, 2, 4, 16})); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !addr_wr && !bad_combo && ctrl_q.dmode == DM_DOWN)
      |=> (($past(dst_addr) - dst_addr) inside {1, 2, 4})); // R4
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !addr_wr && ctrl_q.dmode == DM_HOLD) |=> $stable(dst_addr)); // R2

endmodule

// File: tb/sim_dma_chan_slice.sv
`timescale 1ns/1ps
module sim_dma_chan_slice;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  xfer_size = '0;
  logic        dual_addr = 1'b0, dst_xy = 1'b0, chan_active = 1'b0;
  logic        rd_phase = 1'b0, wr_phase = 1'b0, beat_done = 1'b0;
  logic [31:0] dst_addr, dst_addr1;
  logic [3:0]  ctrl_rd, ctrl_rd1;
  logic        dack, dack1, cfg_err, cfg_err1;

  int vec = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_slice #(.CH_ID(0), .ADDR_W(32)) u0 (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .xfer_size, .dual_addr, .dst_xy,
    .chan_active, .rd_phase, .wr_phase, .beat_done,
    .dst_addr(dst_addr), .ctrl_rd(ctrl_rd), .dack(dack), .cfg_err(cfg_err));

  dma_chan_slice #(.CH_ID(1), .ADDR_W(32)) u1 (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .xfer_size, .dual_addr, .dst_xy,
    .chan_active, .rd_phase, .wr_phase, .beat_done,
    .dst_addr(dst_addr1), .ctrl_rd(ctrl_rd1), .dack(dack1), .cfg_err(cfg_err1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_beat();
    @(negedge clk);
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
  endtask

  function automatic logic model_bad(input int m, input int s, input logic xy);
    return (m == 3) || (m == 2 && s == 3) || (m == 0 && s == 3 && xy);
  endfunction

  function automatic logic [31:0] model_step(input int s);
    return (s == 3) ? 32'd16 : (32'd1 << s);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_a;
    logic        exp_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", {28'd0, ctrl_rd}, 32'd0);
    check("R1 addr", dst_addr, 32'd0);
    check("R1 err", {31'd0, cfg_err}, 32'd0);
    check("R1 dack", {31'd0, dack}, 32'd1);

    // Address stepping sweep: R2 R3 R4 R5 R6 R7
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int x = 0; x < 2; x++) begin
          reg_write(1'b0, m);
          check("R6 err cleared by ctrl write", {31'd0, cfg_err}, 32'd0);
          exp_e = 1'b0;
          exp_a = 32'hFFFF_FFF6;
          reg_write(1'b1, exp_a);
          xfer_size = s[1:0];
          dst_xy = x[0];
          for (int b = 0; b < 3; b++) begin
            pulse_beat();
            if (model_bad(m, s, x[0])) exp_e = 1'b1;
            else if (m == 1) exp_a = exp_a + model_step(s);
            else if (m == 2) exp_a = exp_a - model_step(s);
            check(m == 0 ? "R2 hold addr" : m == 1 ? "R3 up addr" :
                  m == 2 ? "R4 down addr" : "R5 rsvd addr", dst_addr, exp_a);
            check("R5 err flag", {31'd0, cfg_err}, {31'd0, exp_e});
          end
          repeat (3) @(negedge clk);
          check("R7 no move without beat", dst_addr, exp_a);
        end
      end
    end

    // R4 wrap below zero
    dst_xy = 1'b0;
    reg_write(1'b0, 32'd2);
    reg_write(1'b1, 32'd1);
    xfer_size = 2'd2;
    pulse_beat();
    check("R4 down wrap", dst_addr, 32'hFFFF_FFFD);

    // R7 address write wins over beat
    reg_write(1'b0, 32'd1);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_1000; beat_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; beat_done = 1'b0;
    check("R7 load beats step", dst_addr, 32'h0000_1000);

    // R6 illegal beat with ctrl write in the same cycle sets the flag
    reg_write(1'b0, 32'd3);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'd3; beat_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; beat_done = 1'b0;
    check("R6 set wins", {31'd0, cfg_err}, 32'd1);

    // Acknowledge sweep on channel 0: R8 R9 R10 R11
    for (int al = 0; al < 2; al++) begin
      for (int am = 0; am < 2; am++) begin
        reg_write(1'b0, {28'd0, al[0], am[0], 2'b00});
        for (int k = 0; k < 16; k++) begin
          logic hit;
          @(negedge clk);
          dual_addr = k[0]; chan_active = k[1]; rd_phase = k[2]; wr_phase = k[3];
          @(negedge clk);
          if (!k[1]) hit = 1'b0;
          else if (k[0]) hit = am[0] ? k[3] : k[2];
          else hit = k[2] | k[3];
          check(!k[1] ? "R11 R10 idle level" : k[0] ? "R8 R10 dual select" : "R9 R10 single any",
                {31'd0, dack}, {31'd0, al[0] ? hit : ~hit});
        end
      end
    end

    // R12 channel 1 ignores acknowledge bits
    chan_active = 1'b0; rd_phase = 1'b0; wr_phase = 1'b0;
    reg_write(1'b0, 32'hF);
    check("R12 readback ch1", {28'd0, ctrl_rd1}, 32'h3);
    check("R12 readback ch0", {28'd0, ctrl_rd}, 32'hF);
    @(negedge clk);
    dual_addr = 1'b1; chan_active = 1'b1; wr_phase = 1'b1; rd_phase = 1'b0;
    @(negedge clk);
    check("R12 ch1 write phase no ack", {31'd0, dack1}, 32'd1);
    @(negedge clk);
    wr_phase = 1'b0; rd_phase = 1'b1;
    @(negedge clk);
    check("R12 ch1 read phase low ack", {31'd0, dack1}, 32'd0);
    chan_active = 1'b0; rd_phase = 1'b0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule